// File: doc/BRIEF.md
# Registered Command/Address Buffer with Late Parity Check

This block sits in the command/address path of a memory module. It registers a 14-bit data word on the rising clock edge and drives every registered bit onto two identical output copies. Four module-control inputs (clock-enable, chip-select, chip-select-override and termination enable) are registered alongside the word and also fanned out twice. When both select inputs are high at a clock edge, the data outputs and the parity results keep their values.

The controller sends a parity bit for each data word one or two cycles after the word itself. The block keeps the parity of past words in a short pipeline, combines the late bit with the word it belongs to, and drives the result on a partial-parity output. An active-low error flag reports an odd result and is stretched into a two-cycle pulse. A configuration pin selects front mode, for a single module or the first of a pair, or back mode, where the parity input is fed from a front module's partial-parity output. Reset is asynchronous and active-low and takes priority over everything.

Top module: `cmd_addr_regbuf`

## Requirements
- R1: At every rising edge where at least one of `cs_n`, `cso_n` is low, `d` is captured and shown on both `q_a` and `q_b` after that edge.
- R2: At every rising edge, whatever the selects, `ctl_a` and `ctl_b` take {`cke`, `cs_n`, `cso_n`, `odt`} (bit 3 down to bit 0).
- R3: While `rst_n` is low, without waiting for a clock, `q_a`, `q_b`, `ctl_a`, `ctl_b` and `ppo` are 0 and `err_n` is 1.
- R4: At a rising edge where `cs_n` and `cso_n` are both high, `q_a`, `q_b`, `ppo`, `err_n` and the error stretch count keep their values.
- R5: With `cfg_back` low, the parity bit for the word captured at edge k is sampled at edge k+1, and `ppo` and `err_n` for that word appear after edge k+2.
- R6: With `cfg_back` high, the parity bit for the word captured at edge k is sampled at edge k+2, and `ppo` and `err_n` for that word appear after edge k+3.
- R7: `ppo` is the XOR of the parity bit and the 14 bits of its word; `err_n` goes low at the edge where `ppo` becomes 1 (even parity over 15 bits).
- R8: An isolated error holds `err_n` low for exactly two clock cycles.
- R9: An error found while `err_n` is already low restarts the two-cycle window.
- R10: Asserting `rst_n` low during an error pulse drives `err_n` high at once, and no pulse follows after reset is released.
- R11: `cke`, `cs_n`, `cso_n` and `odt` do not enter the parity result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_back | input | 1 | 0: front/single module, 1: back module of a cascade |
| d | input | 14 | Data word |
| cke | input | 1 | Clock-enable control |
| cs_n | input | 1 | Chip select, active low |
| cso_n | input | 1 | Chip-select override, active low |
| odt | input | 1 | Termination enable control |
| par_in | input | 1 | Late parity bit from controller or front module |
| q_a | output | 14 | Registered data, copy A |
| q_b | output | 14 | Registered data, copy B |
| ctl_a | output | 4 | Registered controls {cke, cs_n, cso_n, odt}, copy A |
| ctl_b | output | 4 | Registered controls, copy B |
| ppo | output | 1 | Partial-parity output |
| err_n | output | 1 | Parity error flag, active low |

## Verification
Data and control copies are due one edge after their inputs, while `ppo` and `err_n` are due two edges after the data word in front mode and three in back mode, with the parity bit driven one cycle before that. The bench drives inputs one time unit after a rising edge and samples one unit after the next edge, computing the expected `ppo` from stored histories of words and parity bits shifted by the mode's latency, and the expected `err_n` from the current and previous expected `ppo`. Reset checks sample between edges to show that reset acts without a clock.

// File: rtl/cmd_addr_regbuf.sv
module cmd_addr_regbuf #(
  parameter int DW       = 14,
  parameter int ERR_HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_back,
  input  logic [DW-1:0] d,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          cso_n,
  input  logic          odt,
  input  logic          par_in,
  output logic [DW-1:0] q_a,
  output logic [DW-1:0] q_b,
  output logic [3:0]    ctl_a,
  output logic [3:0]    ctl_b,
  output logic          ppo,
  output logic          err_n
);
  localparam int CW = $clog2(ERR_HOLD + 1);

  logic [DW-1:0] q_r;
  logic [3:0]    c_r;
  logic          p1, s1, ppo_r, err_r;
  logic [CW-1:0] hold;
  logic          gate, pq, chk;

  assign gate = cs_n & cso_n;
  assign pq   = ^q_r;
  assign chk  = par_in ^ (cfg_back ? p1 : pq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      c_r   <= '0;
      p1    <= 1'b0;
      s1    <= 1'b0;
      ppo_r <= 1'b0;
      err_r <= 1'b1;
      hold  <= '0;
    end else begin
      c_r <= {cke, cs_n, cso_n, odt};
      p1  <= pq;
      s1  <= chk;
      if (!gate) begin
        q_r   <= d;
        ppo_r <= s1;
        if (s1) begin
          err_r <= 1'b0;
          hold  <= CW'(ERR_HOLD - 1);
        end else if (hold != '0) begin
          hold <= hold - CW'(1);
        end else begin
          err_r <= 1'b1;
        end
      end
    end
  end

  assign q_a   = q_r;
  assign q_b   = q_r;
  assign ctl_a = c_r;
  assign ctl_b = c_r;
  assign ppo   = ppo_r;
  assign err_n = err_r;

  AST_Q_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_n && cso_n) |=> q_a == $past(d)); // R1

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cso_n) |=> $stable(q_a) && $stable(ppo) && $stable(err_n)); // R4

  AST_ERR_WITH_PPO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> ppo); // R7

  AST_ERR_CLEAR_PPO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> !ppo); // R7

  AST_ERR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n); // R8
endmodule

// File: tb/cmd_addr_regbuf_test.sv
module cmd_addr_regbuf_test;
  localparam int N = 16;
  // {bad, cke, cso_n, odt, d}; cs_n is held low in the table
  localparam logic [17:0] VEC [N] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 14'h0000},
    {1'b0, 1'b1, 1'b0, 1'b1, 14'h0001},
    {1'b0, 1'b0, 1'b0, 1'b1, 14'h3FFF},
    {1'b1, 1'b1, 1'b1, 1'b0, 14'h1234},
    {1'b0, 1'b1, 1'b0, 1'b0, 14'h2AAA},
    {1'b0, 1'b0, 1'b1, 1'b1, 14'h0F0F},
    {1'b0, 1'b1, 1'b0, 1'b0, 14'h0003},
    {1'b1, 1'b1, 1'b0, 1'b1, 14'h2001},
    {1'b1, 1'b0, 1'b1, 1'b0, 14'h1555},
    {1'b0, 1'b1, 1'b0, 1'b0, 14'h0000},
    {1'b0, 1'b1, 1'b1, 1'b1, 14'h3FFE},
    {1'b0, 1'b0, 1'b0, 1'b0, 14'h0100},
    {1'b1, 1'b1, 1'b0, 1'b0, 14'h0777},
    {1'b0, 1'b1, 1'b0, 1'b1, 14'h3C3C},
    {1'b1, 1'b0, 1'b1, 1'b1, 14'h0042},
    {1'b0, 1'b1, 1'b0, 1'b0, 14'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_back = 1'b0;
  logic [13:0] d = '0;
  logic        cke = 1'b0, cs_n = 1'b0, cso_n = 1'b0, odt = 1'b0, par_in = 1'b0;
  logic [13:0] q_a, q_b;
  logic [3:0]  ctl_a, ctl_b;
  logic        ppo, err_n;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  cmd_addr_regbuf uut (
    .clk(clk), .rst_n(rst_n), .cfg_back(cfg_back), .d(d), .cke(cke),
    .cs_n(cs_n), .cso_n(cso_n), .odt(odt), .par_in(par_in),
    .q_a(q_a), .q_b(q_b), .ctl_a(ctl_a), .ctl_b(ctl_b), .ppo(ppo), .err_n(err_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    d = '0; cke = 1'b0; cs_n = 1'b0; cso_n = 1'b0; odt = 1'b0; par_in = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    idle();
    cfg_back = mode;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_table(input logic mode);
    logic [13:0] dh [N];
    logic        ph [N];
    logic        eh [N];
    int lag, lat;
    lag = mode ? 2 : 1;
    lat = lag + 1;
    do_reset(mode);
    for (int i = 0; i < N; i++) begin
      logic pk, pd, pp, ep, ee;
      d = VEC[i][13:0]; cke = VEC[i][16]; cso_n = VEC[i][15]; odt = VEC[i][14];
      cs_n = 1'b0;
      pk = (i >= lag) ? ^VEC[i-lag][13:0] : 1'b0;
      par_in = pk ^ VEC[i][17];
      dh[i] = d; ph[i] = par_in;
      edge_step();
      chk("R1 q_a", q_a, dh[i]);
      chk("R1 q_b", q_b, dh[i]);
      chk("R2 ctl_a", ctl_a, {VEC[i][16], 1'b0, VEC[i][15], VEC[i][14]});
      chk("R2 ctl_b", ctl_b, {VEC[i][16], 1'b0, VEC[i][15], VEC[i][14]});
      pd = (i >= lat) ? ^dh[i-lat] : 1'b0;
      pp = (i >= 1) ? ph[i-1] : 1'b0;
      ep = pd ^ pp;
      eh[i] = ep;
      ee = !(ep | ((i >= 1) ? eh[i-1] : 1'b0));
      // R11: control bits vary in the table and are absent from the expected parity
      if (mode) chk("R6 R7 R11 ppo back", ppo, ep);
      else      chk("R5 R7 R11 ppo front", ppo, ep);
      chk("R8 R9 err_n", err_n, ee);
    end
  endtask

  task automatic raise_error();
    do_reset(1'b0);
    d = 14'h0001; par_in = 1'b0;
    edge_step();
    d = '0; par_in = 1'b0;
    edge_step();
    edge_step();
    chk("R7 ppo set", ppo, 1);
    chk("R7 err_n low", err_n, 0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #2;
    chk("R3 q_a reset", q_a, 0);
    chk("R3 q_b reset", q_b, 0);
    chk("R3 ctl reset", {ctl_a, ctl_b}, 0);
    chk("R3 ppo reset", ppo, 0);
    chk("R3 err_n reset", err_n, 1);

    run_table(1'b0);
    run_table(1'b1);

    // R4 gating while an error pulse is active
    raise_error();
    d = 14'h0005; cs_n = 1'b1; cso_n = 1'b1; cke = 1'b1; odt = 1'b1;
    edge_step();
    chk("R4 q_a hold", q_a, 0);
    chk("R4 ppo hold", ppo, 1);
    chk("R4 err_n hold", err_n, 0);
    chk("R2 ctl while gated", ctl_a, 4'b1111);
    edge_step();
    chk("R4 err_n hold second", err_n, 0);
    d = 14'h0006; cs_n = 1'b0; cso_n = 1'b1; cke = 1'b0; odt = 1'b0;
    edge_step();
    chk("R1 one select low", q_a, 14'h0006);
    chk("R4 stretch resumes", err_n, 0);
    edge_step();
    chk("R8 pulse ends", err_n, 1);

    // R10 reset in the middle of a pulse
    raise_error();
    #1 rst_n = 1'b0;
    #1;
    chk("R10 err_n released", err_n, 1);
    chk("R3 ppo async", ppo, 0);
    chk("R3 q_a async", q_a, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle();
    edge_step();
    chk("R10 err_n after release", err_n, 1);
    edge_step();
    chk("R10 err_n stays high", err_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule